// File: doc/BRIEF.md
# Register-Format Integer Execution Unit

This unit takes one 32-bit register-format instruction word together with the two source operand values already read from the register file. It decodes the word, performs one of six integer operations (add, subtract, bitwise OR, signed set-less-than, left shift by a constant, left shift by a register amount) and presents the registered outcome one clock later. The outcome has four parts: a result word, the destination register index, a write-enable for the register file and a flag for an unsupported encoding.

The instruction word is split, from the most significant bit down, into opcode (6 bits), first source index (5), second source index (5), destination index (5), shift amount (5) and function selector (6). The shift amount comes from a different place for each shift. The constant shift takes it from the shift amount field. The variable shift takes it from the low five bits of the first source operand value. Both shifts move the second source operand.

An issue strobe marks a valid input word. A matching valid strobe on the output follows exactly one cycle later. Nothing stalls the unit, so one word can be accepted on every cycle.

Top module: `rfmt_exec_unit`

## Requirements
- R1: An instruction is accepted only when its opcode (bits 31:26) is 0; any other opcode is treated as unsupported, whatever its function selector (bits 5:0) holds.
- R2: Function 0x20 produces first operand plus second operand, modulo 2^32, with no overflow indication.
- R3: Function 0x22 produces first operand minus second operand, modulo 2^32, with no overflow indication.
- R4: Function 0x25 produces the bitwise OR of the two operands.
- R5: Function 0x2A produces 1 when the first operand is less than the second as two's-complement signed numbers, and 0 otherwise.
- R6: Function 0x00 produces the second operand shifted left by the shift amount field (bits 10:6), with zero fill; the first operand has no effect.
- R7: Function 0x04 produces the second operand shifted left by bits 4:0 of the first operand value; the upper 27 bits of that operand and the shift amount field have no effect.
- R8: An unsupported opcode or function selector sets the illegal flag, clears the write-enable and forces the result to zero.
- R9: A supported instruction whose destination index (bits 15:11) is 0 clears the write-enable and leaves the illegal flag clear.
- R10: The output valid strobe is high exactly one cycle after an issue strobe, and the destination index output then carries bits 15:11 of the issued word.
- R11: In a cycle following one with no issue strobe, output valid, write-enable and illegal flag are low, while result and destination index keep their previous values.
- R12: While reset (active low) is applied, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the current instruction word |
| instr | input | 32 | Register-format instruction word |
| src_a | input | 32 | Value of the first source register |
| src_b | input | 32 | Value of the second source register |
| out_valid | output | 1 | Registered outcome is valid |
| result | output | 32 | Computed result |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register file write-enable |
| bad_func | output | 1 | Unsupported opcode or function selector |

## Verification
The directed tests go after arithmetic wrap-around at both ends of the range and the sign boundary of set-less-than. An unsigned comparator would report -1 as larger than 1, and a trapping adder would not return zero from all-ones plus one. The variable shift is driven with a first operand whose upper bits are set and with a nonzero shift amount field. A unit that used the wrong shift source or too many amount bits would then return a visibly different word. Further tests cover a supported function under a nonzero opcode, writes aimed at register 0, and idle cycles between issues; each would expose a unit that leaks a write, leaves a stale result, or drops the hold behaviour.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 6;
    localparam int REG_IDX_W = 5;
    localparam int SHAMT_W   = 5;
    localparam int FUNCT_W   = 6;

    localparam logic [OPC_W-1:0]   OPC_REG = 6'h00;
    localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FUNCT_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FUNCT_W-1:0] FN_SLLV = 6'h04;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_OR,
        OP_SLT,
        OP_SLL,
        OP_SLLV
    } exu_op_e;

    typedef struct packed {
        logic [OPC_W-1:0]     opc;
        logic [REG_IDX_W-1:0] rs;
        logic [REG_IDX_W-1:0] rt;
        logic [REG_IDX_W-1:0] rd;
        logic [SHAMT_W-1:0]   shamt;
        logic [FUNCT_W-1:0]   funct;
    } rfmt_word_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  rfmt_word_t word,
    output exu_op_e    op,
    output logic       legal
);

    exu_op_e fn_op;

    always_comb begin
        case (word.funct)
            FN_ADD:  fn_op = OP_ADD;
            FN_SUB:  fn_op = OP_SUB;
            FN_OR:   fn_op = OP_OR;
            FN_SLT:  fn_op = OP_SLT;
            FN_SLL:  fn_op = OP_SLL;
            FN_SLLV: fn_op = OP_SLLV;
            default: fn_op = OP_NONE;
        endcase
    end

    assign legal = (word.opc == OPC_REG) && (fn_op != OP_NONE);
    assign op    = legal ? fn_op : OP_NONE;

endmodule

// File: rtl/exu_lshift.sv
module exu_lshift #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   data,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   out
);

    logic [W-1:0] stage [0:SHW];

    assign stage[0] = data;

    for (genvar g = 0; g < SHW; g++) begin : g_stage
        assign stage[g+1] = amt[g] ? (stage[g] << (2 ** g)) : stage[g];
    end

    assign out = stage[SHW];

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  exu_op_e            op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [W-1:0]       res
);

    logic [SHW-1:0] sh_amt;
    logic [W-1:0]   sh_out;
    logic           lt;

    assign sh_amt = (op == OP_SLLV) ? a[SHW-1:0] : shamt[SHW-1:0];
    assign lt     = $signed(a) < $signed(b);

    exu_lshift #(.W(W)) u_lshift (
        .data (b),
        .amt  (sh_amt),
        .out  (sh_out)
    );

    always_comb begin
        case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_OR:   res = a | b;
            OP_SLT:  res = {{(W-1){1'b0}}, lt};
            OP_SLL,
            OP_SLLV: res = sh_out;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/rfmt_exec_unit.sv
module rfmt_exec_unit
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [XLEN-1:0]      src_a,
    input  logic [XLEN-1:0]      src_b,
    output logic                 out_valid,
    output logic [XLEN-1:0]      result,
    output logic [REG_IDX_W-1:0] dest_idx,
    output logic                 wr_en,
    output logic                 bad_func
);

    typedef struct packed {
        logic                 vld;
        logic [XLEN-1:0]      res;
        logic [REG_IDX_W-1:0] dst;
        logic                 we;
        logic                 bad;
    } out_state_t;

    rfmt_word_t word;
    exu_op_e    op;
    logic       legal;
    logic [XLEN-1:0] alu_res;
    out_state_t st_d, st_q;

    assign word = rfmt_word_t'(instr);

    exu_decode u_decode (
        .word  (word),
        .op    (op),
        .legal (legal)
    );

    exu_alu #(.W(XLEN)) u_alu (
        .op    (op),
        .a     (src_a),
        .b     (src_b),
        .shamt (word.shamt),
        .res   (alu_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.we  = 1'b0;
        st_d.bad = 1'b0;
        if (in_valid) begin
            st_d.dst = word.rd;
            if (legal) begin
                st_d.res = alu_res;
                st_d.we  = (word.rd != '0);
            end else begin
                st_d.res = '0;
                st_d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign dest_idx  = st_q.dst;
    assign wr_en     = st_q.we;
    assign bad_func  = st_q.bad;

endmodule

// File: rtl/exu_checker.sv
module exu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [4:0]  dest_idx,
    input logic        wr_en,
    input logic        bad_func
);

    AST_ISSUE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

    AST_DEST_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> dest_idx == $past(instr[15:11])); // R10

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bad_func |-> (!wr_en && result == 32'h0)); // R8

    AST_NONZERO_OPC_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] != 6'h00) |=> bad_func); // R1

    AST_ZERO_DEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dest_idx == 5'd0) |-> !wr_en); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && !bad_func && $stable(result))); // R11

    AST_ADD_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'h00 && instr[5:0] == 6'h20)
        |=> result == $past(src_a) + $past(src_b)); // R2

    AST_SLT_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'h00 && instr[5:0] == 6'h2A)
        |=> result == {31'h0, $signed($past(src_a)) < $signed($past(src_b))}); // R5

endmodule

bind rfmt_exec_unit exu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .dest_idx  (dest_idx),
    .wr_en     (wr_en),
    .bad_func  (bad_func)
);

// File: tb/rfmt_exec_unit_tb.sv
module rfmt_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  dest_idx;
    logic        wr_en;
    logic        bad_func;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    rfmt_exec_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result),
        .dest_idx  (dest_idx),
        .wr_en     (wr_en),
        .bad_func  (bad_func)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd,
                                       input logic [4:0] sa, input logic [5:0] fn);
        return {opc, rs, rt, rd, sa, fn};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Issue one word, then check every output one cycle later.
    task automatic issue(input string req, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] exp_res,
                         input logic exp_bad);
        logic exp_we;
        exp_we = !exp_bad && (w[15:11] != 5'd0);
        @(negedge clk);
        instr = w; src_a = a; src_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " result"}, result, exp_res);
        chk({req, " out_valid R10"}, {31'h0, out_valid}, 32'h1);
        chk({req, " dest_idx R10"}, {27'h0, dest_idx}, {27'h0, w[15:11]});
        chk({req, " wr_en"}, {31'h0, wr_en}, {31'h0, exp_we});
        chk({req, " bad_func"}, {31'h0, bad_func}, {31'h0, exp_bad});
    endtask

    task automatic t_reset;
        chk("R12 out_valid", {31'h0, out_valid}, 32'h0);
        chk("R12 result", result, 32'h0);
        chk("R12 dest_idx", {27'h0, dest_idx}, 32'h0);
        chk("R12 wr_en", {31'h0, wr_en}, 32'h0);
        chk("R12 bad_func", {31'h0, bad_func}, 32'h0);
    endtask

    task automatic t_add;
        issue("R2 add", mk(6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'd1000, 32'd234, 32'd1234, 1'b0);
        issue("R2 add wrap", mk(6'h00, 5'd4, 5'd5, 5'd6, 5'd0, 6'h20), 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0);
        issue("R2 add sign", mk(6'h00, 5'd4, 5'd5, 5'd7, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0);
    endtask

    task automatic t_sub;
        issue("R3 sub neg", mk(6'h00, 5'd1, 5'd2, 5'd8, 5'd0, 6'h22), 32'd5, 32'd7, 32'hFFFF_FFFE, 1'b0);
        issue("R3 sub wrap", mk(6'h00, 5'd1, 5'd2, 5'd9, 5'd0, 6'h22), 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_or;
        issue("R4 or", mk(6'h00, 5'd1, 5'd2, 5'd10, 5'd0, 6'h25), 32'hF0F0_0000, 32'h0F00_00FF, 32'hFFF0_00FF, 1'b0);
    endtask

    task automatic t_slt;
        issue("R5 slt neg<pos", mk(6'h00, 5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'hFFFF_FFFF, 32'h1, 32'h1, 1'b0);
        issue("R5 slt pos<neg", mk(6'h00, 5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'h1, 32'hFFFF_FFFF, 32'h0, 1'b0);
        issue("R5 slt equal", mk(6'h00, 5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'h42, 32'h42, 32'h0, 1'b0);
        issue("R5 slt min", mk(6'h00, 5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'h8000_0000, 32'h7FFF_FFFF, 32'h1, 1'b0);
    endtask

    task automatic t_sll;
        issue("R6 sll 0", mk(6'h00, 5'd1, 5'd2, 5'd12, 5'd0, 6'h00), 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, 1'b0);
        issue("R6 sll 4", mk(6'h00, 5'd1, 5'd2, 5'd12, 5'd4, 6'h00), 32'h0000_001F, 32'h1234_5678, 32'h2345_6780, 1'b0);
        issue("R6 sll 31", mk(6'h00, 5'd1, 5'd2, 5'd12, 5'd31, 6'h00), 32'h0, 32'h0000_0003, 32'h8000_0000, 1'b0);
    endtask

    task automatic t_sllv;
        issue("R7 sllv low bits", mk(6'h00, 5'd1, 5'd2, 5'd13, 5'd7, 6'h04), 32'hFFFF_FFE3, 32'h0000_0101, 32'h0000_0808, 1'b0);
        issue("R7 sllv 32 is 0", mk(6'h00, 5'd1, 5'd2, 5'd13, 5'd9, 6'h04), 32'h0000_0020, 32'hABCD_0001, 32'hABCD_0001, 1'b0);
        issue("R7 sllv 17", mk(6'h00, 5'd1, 5'd2, 5'd13, 5'd0, 6'h04), 32'h0000_0011, 32'h0000_FFFF, 32'hFFFE_0000, 1'b0);
    endtask

    task automatic t_illegal;
        issue("R8 bad funct", mk(6'h00, 5'd1, 5'd2, 5'd14, 5'd0, 6'h21), 32'h5, 32'h6, 32'h0, 1'b1);
        issue("R1 nonzero opc", mk(6'h23, 5'd1, 5'd2, 5'd14, 5'd0, 6'h20), 32'h5, 32'h6, 32'h0, 1'b1);
        issue("R8 funct 3F", mk(6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h3F), 32'h5, 32'h6, 32'h0, 1'b1);
    endtask

    task automatic t_zero_dest;
        issue("R9 add to r0", mk(6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'h3, 32'h4, 32'h7, 1'b0);
        issue("R9 or to r0", mk(6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h25), 32'h3, 32'h4, 32'h7, 1'b0);
    endtask

    task automatic t_idle;
        issue("R11 setup", mk(6'h00, 5'd1, 5'd2, 5'd21, 5'd0, 6'h20), 32'h10, 32'h20, 32'h30, 1'b0);
        @(negedge clk);
        chk("R11 out_valid low", {31'h0, out_valid}, 32'h0);
        chk("R11 wr_en low", {31'h0, wr_en}, 32'h0);
        chk("R11 bad_func low", {31'h0, bad_func}, 32'h0);
        chk("R11 result held", result, 32'h30);
        chk("R11 dest held", {27'h0, dest_idx}, 32'd21);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_add();
        t_sub();
        t_or();
        t_slt();
        t_sll();
        t_sllv();
        t_illegal();
        t_zero_dest();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule